// File: doc/BRIEF.md
# Per-Core Banked Timer Router

This block holds one countdown timer for each processor core (one to four cores, fixed by a parameter) and steers register accesses from a shared bus to them. The address space is split into 32-byte windows. Window 0 is an alias: it always reaches the timer that belongs to the core named on the request's core-ID input, so every core can run the same code to reach its own timer. Windows 1 to N give fixed access, with window k reaching the timer of core k-1, so any core can inspect or program any other core's timer. Each timer drives its own interrupt line.

A request is presented for one cycle. The response (valid, error flag and read data) appears in the next cycle. A small state machine holds the kind of response that is pending. Its states are ST_IDLE (no response), ST_READ (read data valid), ST_WRITE (write acknowledged) and ST_ERROR (rejected access). Each cycle it moves from any state to ST_IDLE when there is no request, to ST_ERROR on a rejected request, to ST_WRITE on an accepted write, and to ST_READ on an accepted read. Accesses are rejected when they are not 32-bit, when they fall in a window above N, or when they use the alias window with a core ID of N or more. A rejected access changes no timer, reads as zero and raises the error flag for one cycle.

Each timer has four registers. The reload value is at offset 0x0. The live count is at offset 0x4. Control is at offset 0x8: bit 0 enables counting, bit 1 selects automatic reload, and bits 15:8 hold the prescale value P. The event flag is at offset 0xC in bit 0 and is cleared by writing 1.

Top module: `core_timer_router`

## Requirements
- R1: After reset, every timer register reads zero, every interrupt line is low and no response is valid.
- R2: An accepted access to window 0 (address bits 7:5 equal 0) reaches the timer whose index equals req_core.
- R3: An accepted access to window k, for 1 <= k <= CORES, reaches timer k-1. Window k covers byte addresses 0x20*k to 0x20*k+0x1F.
- R4: Within a window, address bits 4:2 select the register. 0 is the reload value, and a write there sets both the reload value and the count. 1 is the count. 2 is control. 3 is the event flag. Offsets 4 to 7 read zero, ignore writes and do not raise the error flag.
- R5: A request in cycle t produces rsp_valid in cycle t+1 and in no other cycle. Read data reflects the register state in cycle t.
- R6: A request with req_size other than 2'b10 (32-bit) raises rsp_err, reads zero and changes no timer.
- R7: A window-0 request with req_core >= CORES raises rsp_err, reads zero and changes no timer.
- R8: A request to a window above CORES raises rsp_err, reads zero and changes no timer.
- R9: irq[i] follows timer i's event flag. The flag is set when the count steps from 1 to 0. Writing 1 to bit 0 of the flag register clears it, and writing 0 leaves it set.
- R10: While enabled with a nonzero count, the count drops by one every P+1 cycles. With auto-reload set, expiry reloads the count from the reload value. Otherwise the count stays at 0.
- R11: A control write that turns enable from 0 to 1, while the count is 0 and auto-reload is set, copies the reload value into the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size, 2'b10 = 32-bit |
| req_core | input | CID_W | ID of the requesting core |
| req_addr | input | ADDR_W | Byte address within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is a rejected access |
| rsp_rdata | output | 32 | Read data (zero unless an accepted read) |
| irq | output | CORES | Per-core timer event lines |

## Verification
The hardest cases to reach are the ones where one timer is addressed through two different routes. The same timer can be reached through the alias window and through its fixed window, and cross-core writes through the alias must be ruled out. The stimulus writes distinct values to each timer through one route and reads them back through the other. It then sends an alias access with an out-of-range core ID and reads every timer's fixed window to show that none of them changed. The expiry timing tests enable a timer with known count and prescale values, then sample the interrupt line on the cycle before and the cycle of the expected event.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_ERROR = 2'd3
    } rsp_state_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [2:0] OFF_RELOAD = 3'd0;
    localparam logic [2:0] OFF_COUNT  = 3'd1;
    localparam logic [2:0] OFF_CTRL   = 3'd2;
    localparam logic [2:0] OFF_FLAG   = 3'd3;
endpackage

// File: rtl/ctr_decode.sv
module ctr_decode #(
    parameter int CORES  = 3,
    parameter int CID_W  = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [1:0]        size,
    input  logic [CID_W-1:0]  core,
    input  logic [ADDR_W-1:0] addr,
    output logic [CORES-1:0]  target,
    output logic              reject,
    output logic [2:0]        offset
);
    import ctr_pkg::*;

    localparam int WIN_W = ADDR_W - 5;

    logic [WIN_W-1:0] win;
    logic             bad_core;
    logic             bad_win;

    assign win    = addr[ADDR_W-1:5];
    assign offset = addr[4:2];

    always_comb begin
        bad_core = (win == '0) && (int'(core) >= CORES);
        bad_win  = int'(win) > CORES;
        reject   = valid && ((size != SIZE_WORD) || bad_core || bad_win);
        target   = '0;
        if (valid && !reject) begin
            for (int i = 0; i < CORES; i++) begin
                if (win == '0) target[i] = (int'(core) == i);
                else           target[i] = (int'(win) == i + 1);
            end
        end
    end

    // R7 / R8: a rejected request never selects a timer
    a_r7_reject_no_target: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (target == '0));

    // R2 / R3: an accepted request selects exactly one timer
    a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !reject) |-> $onehot(target));
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer #(
    parameter int DW    = 32,
    parameter int PRE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_off,
    output logic [DW-1:0] rd_data,
    output logic          event_flag
);
    import ctr_pkg::*;

    logic [DW-1:0]    reload_q, count_q, ctrl_q;
    logic             flag_q;
    logic [PRE_W-1:0] pre_cnt_q;
    logic             enable, auto_rl, tick;
    logic [PRE_W-1:0] pre_val;

    assign enable  = ctrl_q[0];
    assign auto_rl = ctrl_q[1];
    assign pre_val = ctrl_q[8 +: PRE_W];
    assign tick    = enable && (pre_cnt_q == pre_val);

    always_ff @(posedge clk) begin
        if (!rst_n)         pre_cnt_q <= '0;
        else if (!enable)   pre_cnt_q <= '0;
        else if (tick)      pre_cnt_q <= '0;
        else                pre_cnt_q <= pre_cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (tick && count_q != '0) begin
                if (count_q == DW'(1)) begin
                    flag_q  <= 1'b1;
                    count_q <= auto_rl ? reload_q : '0;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
            if (wr_en) begin
                unique case (wr_off)
                    OFF_RELOAD: begin
                        reload_q <= wr_data;
                        count_q  <= wr_data;
                    end
                    OFF_COUNT: count_q <= wr_data;
                    OFF_CTRL: begin
                        ctrl_q <= wr_data;
                        if (!enable && wr_data[0] && wr_data[1] && count_q == '0)
                            count_q <= reload_q;
                    end
                    OFF_FLAG: if (wr_data[0] && !(tick && count_q == DW'(1)))
                                  flag_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_off)
            OFF_RELOAD: rd_data = reload_q;
            OFF_COUNT:  rd_data = count_q;
            OFF_CTRL:   rd_data = ctrl_q;
            OFF_FLAG:   rd_data = {{(DW-1){1'b0}}, flag_q};
            default:    rd_data = '0;
        endcase
    end

    assign event_flag = flag_q;

    // R9: expiry of a running count raises the flag on the next cycle
    a_r9_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q == DW'(1)) |=> flag_q);

    // R10: a disabled timer holds its count unless written
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !wr_en) |=> $stable(count_q));
endmodule

// File: rtl/core_timer_router.sv
module core_timer_router #(
    parameter int CORES  = 3,
    parameter int CID_W  = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [CID_W-1:0]  req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [CORES-1:0]  irq
);
    import ctr_pkg::*;

    localparam int DW = 32;

    logic [CORES-1:0] target, wr_vec;
    logic             reject;
    logic [2:0]       offset;
    logic [DW-1:0]    tmr_rd [CORES];
    logic [DW-1:0]    rd_mux, rd_q;
    rsp_state_e       state_q, state_d;

    ctr_decode #(.CORES(CORES), .CID_W(CID_W), .ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .size(req_size),
        .core(req_core), .addr(req_addr),
        .target(target), .reject(reject), .offset(offset)
    );

    assign wr_vec = req_write ? target : '0;

    for (genvar g = 0; g < CORES; g++) begin : g_tmr
        ctr_timer #(.DW(DW)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_vec[g]), .wr_off(offset), .wr_data(req_wdata),
            .rd_off(offset), .rd_data(tmr_rd[g]), .event_flag(irq[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < CORES; i++)
            if (target[i]) rd_mux = rd_mux | tmr_rd[i];
    end

    always_comb begin
        if (!req_valid)     state_d = ST_IDLE;
        else if (reject)    state_d = ST_ERROR;
        else if (req_write) state_d = ST_WRITE;
        else                state_d = ST_READ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            rd_q    <= rd_mux;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  begin rsp_valid = 1'b1; rsp_rdata = rd_q; end
            ST_WRITE: rsp_valid = 1'b1;
            ST_ERROR: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
        endcase
    end

    // R5: one response exactly one cycle after each request
    a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6: an error response never carries data
    a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R2: at most one timer is written per cycle
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
endmodule

// File: tb/core_timer_router_tb.sv
module core_timer_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CORES = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_size = 2'b10;
    logic [1:0]  req_core = 0;
    logic [7:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [CORES-1:0] irq;

    int n_checks = 0, n_fail = 0;
    logic        got_err;
    logic [31:0] got_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_timer_router #(.CORES(CORES), .CID_W(2), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_core(req_core), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one access: driven at a falling edge, response sampled one cycle later
    task automatic access(input logic wr, input logic [1:0] sz, input logic [1:0] core,
                          input logic [7:0] addr, input logic [31:0] data);
        req_valid = 1; req_write = wr; req_size = sz; req_core = core;
        req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 0;
        check("R5 rsp_valid", {31'b0, rsp_valid}, 1);
        got_err  = rsp_err;
        got_data = rsp_rdata;
    endtask

    task automatic wr(input logic [1:0] core, input logic [7:0] addr, input logic [31:0] d);
        access(1, 2'b10, core, addr, d);
    endtask

    task automatic rd(input logic [1:0] core, input logic [7:0] addr);
        access(0, 2'b10, core, addr, 0);
    endtask

    task automatic t_reset;
        check("R1 irq", {29'b0, irq}, 0);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
        for (int k = 1; k <= CORES; k++) begin
            rd(0, 8'(k*32));     check("R1 reload", got_data, 0);
            rd(0, 8'(k*32 + 8)); check("R1 ctrl", got_data, 0);
        end
        @(negedge clk);
        check("R5 idle", {31'b0, rsp_valid}, 0);
    endtask

    task automatic t_alias;
        wr(1, 8'h00, 32'h11);
        rd(0, 8'h40); check("R2 alias core1 -> window2", got_data, 32'h11);
        rd(0, 8'h00); check("R2 alias core0 untouched", got_data, 0);
        wr(0, 8'h20, 32'h22);
        rd(0, 8'h00); check("R3 window1 -> timer0", got_data, 32'h22);
        wr(0, 8'h60, 32'h33);
        rd(2, 8'h00); check("R3 window3 -> timer2", got_data, 32'h33);
        rd(2, 8'h64); check("R4 reload write sets count", got_data, 32'h33);
        check("R5 read no err", {31'b0, got_err}, 0);
    endtask

    task automatic t_offsets;
        wr(0, 8'h30, 32'hABCD);
        check("R4 unmapped write no err", {31'b0, got_err}, 0);
        rd(0, 8'h30); check("R4 unmapped reads zero", got_data, 0);
        rd(0, 8'h20); check("R4 unmapped write ignored", got_data, 32'h22);
        wr(0, 8'h24, 32'h7);
        rd(0, 8'h24); check("R4 count write", got_data, 32'h7);
        rd(0, 8'h20); check("R4 count write keeps reload", got_data, 32'h22);
    endtask

    task automatic t_errors;
        access(1, 2'b01, 0, 8'h20, 32'h99);
        check("R6 size err", {31'b0, got_err}, 1);
        access(0, 2'b11, 0, 8'h20, 0);
        check("R6 size err read", {31'b0, got_err}, 1);
        check("R6 err data zero", got_data, 0);
        rd(0, 8'h20); check("R6 write ignored", got_data, 32'h22);
        wr(3, 8'h00, 32'h55);
        check("R7 bad core err", {31'b0, got_err}, 1);
        for (int k = 1; k <= CORES; k++) begin
            rd(0, 8'(k*32));
            check("R7 no timer changed", got_data,
                  (k == 1) ? 32'h22 : (k == 2) ? 32'h11 : 32'h33);
        end
        access(0, 2'b10, 3, 8'h00, 0);
        check("R7 bad core read zero", got_data, 0);
        wr(0, 8'h80, 32'h66);
        check("R8 window4 err", {31'b0, got_err}, 1);
        access(0, 2'b10, 0, 8'hE0, 0);
        check("R8 window7 err", {31'b0, got_err}, 1);
        check("R8 read zero", got_data, 0);
    endtask

    task automatic t_expire_stop;
        wr(0, 8'h60, 32'h3);          // timer2 count 3
        wr(0, 8'h68, 32'h0000_0001);  // enable, P=0, no reload
        @(negedge clk); @(negedge clk);
        check("R9 irq before expiry", {29'b0, irq}, 0);
        @(negedge clk);
        check("R9 irq timer2 only", {29'b0, irq}, 3'b100);
        rd(0, 8'h64); check("R10 stop at zero", got_data, 0);
        wr(0, 8'h6C, 32'h0);
        check("R9 write 0 keeps flag", {29'b0, irq}, 3'b100);
        wr(2, 8'h0C, 32'h1);
        check("R9 W1C clears", {29'b0, irq}, 0);
        wr(0, 8'h68, 32'h0);
    endtask

    task automatic t_expire_reload;
        wr(0, 8'h20, 32'h2);          // timer0 reload/count 2
        wr(0, 8'h28, 32'h0000_0303);  // enable, reload, P=3
        for (int i = 0; i < 7; i++) @(negedge clk);
        check("R10 prescale no early expiry", {29'b0, irq}, 0);
        @(negedge clk);
        check("R10 expiry after 8 cycles", {29'b0, irq}, 3'b001);
        rd(0, 8'h24); check("R10 auto reload", got_data, 32'h2);
        wr(0, 8'h28, 32'h0);
        wr(0, 8'h2C, 32'h1);
    endtask

    task automatic t_enable_load;
        wr(1, 8'h00, 32'h5);
        wr(1, 8'h04, 32'h0);
        rd(1, 8'h04); check("R11 count zero before enable", got_data, 0);
        wr(1, 8'h08, 32'h0000_FF03);
        rd(1, 8'h04); check("R11 enable copies reload", got_data, 32'h5);
        rd(0, 8'h48); check("R4 ctrl readback", got_data, 32'hFF03);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset;
                t_alias;
                t_offsets;
                t_errors;
                t_expire_stop;
                t_expire_reload;
                t_enable_load;
            end
            begin
                repeat (20000) @(negedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule